// File: doc/BRIEF.md
# Buffer Pointer Control Register Bank

This block holds four 8-bit host-visible registers behind a small strobe-based bus. A host selects a register with a 2-bit address, raises chip select, and chooses read or write with a single direction line. Write data is captured while chip select is high and committed when chip select falls. Read data is registered and is valid, with its enable, only during a read access. The bus is split into separate input and output lanes plus an output enable, so that the chip-level pad logic can build the bidirectional pins.

Two of the registers are 7-bit loadable up-counters. They supply the write address and the read address of a 128-word dual-port capture buffer. The write pointer advances on every clock while recording runs. The read pointer either tracks the write pointer during recording or advances once per falling edge of an asynchronous read strobe, depending on two control bits. A miscellaneous control register also drives test-select outputs. A test data register carries a serial shift path with a serial-in bit and a read-only serial-out bit.

Top module: `buf_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset clears every writable bit, both pointers, the serial-out bit, the read data and the read enable. Every register then reads 0.
- R2: A write commits at the first clock edge that samples chip select low after it was high. It uses the address and data sampled at the last edge where chip select was high. Address 0 selects control, 1 the read pointer, 2 the write pointer and 3 the test register, and only the addressed register changes.
- R3: While chip select and read are sampled high at an edge, that edge loads the read data and raises the read enable. The read enable is low at every edge that does not sample a read. The read pointer and write pointer registers return the live pointer in bits 6:0 with bit 7 at 0, and control bit 7 reads 0.
- R4: The write pointer increments by one at every clock edge that samples the recording input high, and wraps from 127 to 0.
- R5: With control bit 0 at 0, the read pointer increments together with the write pointer while recording. With control bit 0 at 1, recording leaves the read pointer unchanged.
- R6: With control bit 1 at 1 and read mode bit 1 at 1 (modes 2 and 3), each falling edge of the asynchronous read strobe increments the read pointer once, on the third clock edge after the strobe is first sampled low. In modes 0 and 1, or with control bit 1 at 0, the strobe has no effect.
- R7: A host write loads either pointer exactly, and the read pointer wraps from 127 to 0.
- R8: Control bit 2 drives the edge-select output (0 rising, 1 falling). Bits 4:3 drive the test channel output, and bit 5 drives the memory-test enable output.
- R9: The test register holds test data in bits 5:0, serial-in in bit 6 and read-only serial-out in bit 7. Writes to bit 7 are ignored. When control bit 6 is set, each access ending at address 3 first applies any write and then shifts, so that {serial-out, test data} becomes {test data, serial-in}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip-select strobe, active high |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Write data lane |
| host_rdata | output | 8 | Registered read data lane |
| host_rdata_oe | output | 1 | Read data drive enable |
| rec_run | input | 1 | Recording active, one write-pointer step per clock |
| rd_mode | input | 2 | Read mode; bit 1 set selects strobe-driven reads |
| rd_strobe | input | 1 | Asynchronous read strobe, advances on its falling edge |
| wr_addr | output | 7 | Write pointer to the buffer |
| rd_addr | output | 7 | Read pointer to the buffer |
| test_edge_sel | output | 1 | Test edge select from control bit 2 |
| test_ch | output | 2 | Test channel from control bits 4:3 |
| mem_test_en | output | 1 | Memory-test enable from control bit 5 |

## Verification
A register write is visible one clock edge after chip select is sampled low, so the bench drops chip select on a falling edge and observes one full cycle later. Read data and its enable appear one edge after a read is sampled, and the enable falls one edge after chip select drops; the bench samples both on the falling edges that follow. Pointer steps land on each edge where recording is sampled high, so the bench holds recording for an exact number of edges. A strobe-driven increment needs three edges through the synchronizer and edge detector, so the bench waits several cycles before it reads the pointer back.

// File: rtl/crb_pkg.sv
package crb_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RPTR = 2'd1,
    SEL_WPTR = 2'd2,
    SEL_TEST = 2'd3
  } reg_sel_e;

  // control register, bit 0 at the bottom; bit 7 reads as zero
  typedef struct packed {
    logic       shift_en;   // bit 6
    logic       mem_test;   // bit 5
    logic [1:0] test_ch;    // bits 4:3
    logic       edge_sel;   // bit 2
    logic       auto_rd;    // bit 1
    logic       no_lock;    // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/crb_bus_if.sv
module crb_bus_if #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 2,
  localparam int unsigned NREG  = 1 << AW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs,
  input  logic                   rnw,
  input  logic [AW-1:0]          addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NREG*DATA_W-1:0] bank,
  output logic                   acc_end,
  output logic                   commit_wr,
  output logic [AW-1:0]          acc_sel,
  output logic [DATA_W-1:0]      acc_data,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rdata_oe
);

  logic              cs_q;
  logic              rnw_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      rnw_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cs_q <= cs;
      if (cs) begin
        rnw_q  <= rnw;
        addr_q <= addr;
        data_q <= wdata;
      end
    end
  end

  assign acc_end   = cs_q & ~cs;
  assign commit_wr = acc_end & ~rnw_q;
  assign acc_sel   = addr_q;
  assign acc_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= cs & rnw;
      if (cs & rnw) rdata <= bank[int'(addr)*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/crb_ptr.sv
module crb_ptr #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] ptr
);

  localparam logic [W-1:0] ONE = 1;

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + ONE;
  end

endmodule

// File: rtl/crb_fall_sync.sv
module crb_fall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign fall = last_q & ~chain[STAGES-1];

endmodule

// File: rtl/crb_test_reg.sv
module crb_test_reg #(
  parameter int unsigned TDR_W = 6,
  localparam int unsigned DATA_W = TDR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              acc_end,
  input  logic              shift_en,
  output logic [DATA_W-1:0] rd_value
);

  logic [TDR_W-1:0] tdr_q;
  logic             sin_q;
  logic             sout_q;
  logic [TDR_W-1:0] tdr_nx;
  logic             sin_nx;

  always_comb begin
    tdr_nx = wr ? wr_data[TDR_W-1:0] : tdr_q;
    sin_nx = wr ? wr_data[TDR_W]     : sin_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tdr_q  <= '0;
      sin_q  <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      sin_q <= sin_nx;
      if (acc_end && shift_en) {sout_q, tdr_q} <= {tdr_nx, sin_nx};
      else                     tdr_q <= tdr_nx;
    end
  end

  assign rd_value = {sout_q, sin_q, tdr_q};

endmodule

// File: rtl/buf_ctrl_regs.sv
module buf_ctrl_regs #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned AW          = 2,
  parameter int unsigned PTR_W       = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NREG       = 1 << AW,
  localparam int unsigned TDR_W      = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs,
  input  logic              host_rnw,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  input  logic              rec_run,
  input  logic [1:0]        rd_mode,
  input  logic              rd_strobe,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              test_edge_sel,
  output logic [1:0]        test_ch,
  output logic              mem_test_en
);
  import crb_pkg::*;

  logic              acc_end;
  logic              commit_wr;
  logic [AW-1:0]     acc_sel;
  logic [DATA_W-1:0] acc_data;
  logic [NREG*DATA_W-1:0] bank;
  logic [DATA_W-1:0] test_val;
  ctrl_t             ctrl_q;
  logic              strobe_fall;
  logic              misc_no_lock;
  logic              rd_step;

  crb_bus_if #(.DATA_W(DATA_W), .AW(AW)) u_bus (
    .clk(clk), .rst(rst), .cs(host_cs), .rnw(host_rnw), .addr(host_addr),
    .wdata(host_wdata), .bank(bank), .acc_end(acc_end), .commit_wr(commit_wr),
    .acc_sel(acc_sel), .acc_data(acc_data), .rdata(host_rdata),
    .rdata_oe(host_rdata_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (commit_wr && acc_sel == SEL_CTRL) ctrl_q <= ctrl_t'(acc_data[CTRL_W-1:0]);
  end

  crb_ptr #(.W(PTR_W)) u_wptr (
    .clk(clk), .rst(rst),
    .load(commit_wr && acc_sel == SEL_WPTR), .load_val(acc_data[PTR_W-1:0]),
    .step(rec_run), .ptr(wr_addr)
  );

  crb_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(rd_strobe), .fall(strobe_fall)
  );

  assign misc_no_lock = ctrl_q.no_lock;
  assign rd_step = (rec_run & ~ctrl_q.no_lock) |
                   (strobe_fall & ctrl_q.auto_rd & rd_mode[1]);

  crb_ptr #(.W(PTR_W)) u_rptr (
    .clk(clk), .rst(rst),
    .load(commit_wr && acc_sel == SEL_RPTR), .load_val(acc_data[PTR_W-1:0]),
    .step(rd_step), .ptr(rd_addr)
  );

  crb_test_reg #(.TDR_W(TDR_W)) u_test (
    .clk(clk), .rst(rst),
    .wr(commit_wr && acc_sel == SEL_TEST), .wr_data(acc_data),
    .acc_end(acc_end && acc_sel == SEL_TEST), .shift_en(ctrl_q.shift_en),
    .rd_value(test_val)
  );

  assign bank = {test_val,
                 {{(DATA_W-PTR_W){1'b0}}, wr_addr},
                 {{(DATA_W-PTR_W){1'b0}}, rd_addr},
                 {{(DATA_W-CTRL_W){1'b0}}, ctrl_q}};

  assign test_edge_sel = ctrl_q.edge_sel;
  assign test_ch       = ctrl_q.test_ch;
  assign mem_test_en   = ctrl_q.mem_test;

endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
  parameter int unsigned PTR_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             host_cs,
  input logic             host_rnw,
  input logic             host_rdata_oe,
  input logic             rec_run,
  input logic             commit_wr,
  input logic             strobe_fall,
  input logic             misc_no_lock,
  input logic [PTR_W-1:0] wr_addr,
  input logic [PTR_W-1:0] rd_addr
);

  localparam logic [PTR_W-1:0] ONE = 1;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_addr == '0 && rd_addr == '0 && !host_rdata_oe));

  p_oe_after_read_r3: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe |-> $past(host_cs && host_rnw));

  p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rec_run) && !$past(commit_wr))
      |-> wr_addr == $past(wr_addr) + ONE);

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rec_run) && !$past(commit_wr)) |-> $stable(wr_addr));

  p_rd_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rec_run) && !$past(misc_no_lock) && !$past(commit_wr))
      |-> rd_addr == $past(rd_addr) + ONE);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rec_run) && !$past(strobe_fall) && !$past(commit_wr))
      |-> $stable(rd_addr));

endmodule

bind buf_ctrl_regs crb_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .host_cs(host_cs), .host_rnw(host_rnw),
  .host_rdata_oe(host_rdata_oe), .rec_run(rec_run), .commit_wr(commit_wr),
  .strobe_fall(strobe_fall), .misc_no_lock(misc_no_lock),
  .wr_addr(wr_addr), .rd_addr(rd_addr)
);

// File: tb/buf_ctrl_regs_tb.sv
module buf_ctrl_regs_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rnw = 1'b0, strobe = 1'b1, run = 1'b0;
  logic [1:0] addr = '0, mode = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       oe, esel, mtest;
  logic [1:0] tch;
  logic [6:0] wp, rp;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [6:0] m_ctrl, m_wp, m_rp;
  logic [5:0] m_tdr;
  logic       m_sin, m_sout;

  always #2.5 clk = ~clk;

  buf_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .host_cs(cs), .host_rnw(rnw), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata), .host_rdata_oe(oe),
    .rec_run(run), .rd_mode(mode), .rd_strobe(strobe),
    .wr_addr(wp), .rd_addr(rp), .test_edge_sel(esel), .test_ch(tch),
    .mem_test_en(mtest)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, m_ctrl};
      2'd1:    return {1'b0, m_rp};
      2'd2:    return {1'b0, m_wp};
      default: return {m_sout, m_sin, m_tdr};
    endcase
  endfunction

  function automatic void model_shift();
    if (m_ctrl[6]) begin
      m_sout = m_tdr[5];
      m_tdr  = {m_tdr[4:0], m_sin};
    end
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; rnw = 0; addr = a; wdata = d;
    @(negedge clk); cs = 0;
    @(negedge clk);
    case (a)
      2'd0: m_ctrl = d[6:0];
      2'd1: m_rp = d[6:0];
      2'd2: m_wp = d[6:0];
      default: begin m_tdr = d[5:0]; m_sin = d[6]; model_shift(); end
    endcase
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk); cs = 1; rnw = 1; addr = a;
    @(negedge clk);
    e = exp_read(a);
    chk({tag, " R3 data"}, rdata, e);
    chk("R3 oe during read", oe, 1'b1);
    cs = 0;
    @(negedge clk);
    chk("R3 oe after read", oe, 1'b0);
    if (a == 2'd3) model_shift();
  endtask

  task automatic run_rec(input int n);
    @(negedge clk); run = 1;
    repeat (n) @(negedge clk);
    run = 0;
    m_wp = m_wp + 7'(n);
    if (!m_ctrl[0]) m_rp = m_rp + 7'(n);
  endtask

  task automatic strobe_pulse();
    @(negedge clk); strobe = 0;
    repeat (3) @(negedge clk);
    strobe = 1;
    repeat (4) @(negedge clk);
    if (m_ctrl[1] && mode[1]) m_rp = m_rp + 7'd1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    m_ctrl = '0; m_wp = '0; m_rp = '0; m_tdr = '0; m_sin = 0; m_sout = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", oe, 1'b0);
    chk("R1 wr_addr", wp, 7'd0);
    chk("R1 rd_addr", rp, 7'd0);
    chk("R1 rdata", rdata, 8'd0);
    for (int a = 0; a < 4; a++) bus_read(2'(a), "R1 reg");

    // R2 address decode: each write touches only its register
    bus_write(2'd2, 8'h15);
    bus_read(2'd1, "R2 rptr untouched");
    bus_read(2'd0, "R2 ctrl untouched");
    bus_write(2'd1, 8'h8A);
    chk("R7 rptr load", rp, 7'h0A);
    chk("R2 wptr keep", wp, 7'h15);

    // R8 control outputs, R3 bit 7 reads 0
    bus_write(2'd0, 8'hBC);
    chk("R8 edge_sel", esel, 1'b1);
    chk("R8 test_ch", tch, 2'd3);
    chk("R8 mem_test", mtest, 1'b1);
    bus_read(2'd0, "R3 ctrl bit7");
    bus_write(2'd0, 8'h00);
    chk("R8 cleared", {esel, tch, mtest}, 4'd0);

    // R4 wrap of write pointer; R5/R7 lockstep and read pointer wrap
    bus_write(2'd2, 8'd126);
    bus_write(2'd1, 8'd127);
    run_rec(3);
    chk("R4 wrap", wp, 7'd1);
    chk("R7 rp wrap", rp, 7'd2);
    bus_write(2'd0, 8'h01);
    run_rec(5);
    chk("R5 no lock rp", rp, 7'd2);
    chk("R4 step", wp, 7'd6);

    // R6 strobe-driven advance
    bus_write(2'd0, 8'h03);
    mode = 2'd2; strobe_pulse();
    chk("R6 mode2 advance", rp, m_rp);
    mode = 2'd3; strobe_pulse();
    chk("R6 mode3 advance", rp, m_rp);
    mode = 2'd1; strobe_pulse();
    chk("R6 mode1 ignored", rp, 7'd4);
    bus_write(2'd0, 8'h01);
    mode = 2'd3; strobe_pulse();
    chk("R6 disabled ignored", rp, 7'd4);

    // R9 test register
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, "R9 no shift, bit7 ignored");
    bus_write(2'd0, 8'h40);
    bus_write(2'd3, 8'hA5);
    bus_read(2'd3, "R9 shift after write");
    bus_read(2'd3, "R9 shift after read");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned op;
      op = $urandom % 5;
      mode = 2'($urandom);
      case (op)
        0: bus_write(2'($urandom), 8'($urandom));
        1: bus_read(2'($urandom), "R2 random");
        2: run_rec(1 + ($urandom % 9));
        3: strobe_pulse();
        default: begin
          chk("R8 random", {esel, tch, mtest}, {m_ctrl[2], m_ctrl[4:3], m_ctrl[5]});
          chk("R4 random wp", wp, m_wp);
          chk("R5 random rp", rp, m_rp);
        end
      endcase
    end
    finish_run();
  end

endmodule